// File: doc/BRIEF.md
# Boot Memory Remap Controller

This block decides which on-chip memory answers an access in the low boot window of the address map. Three things set the choice. A remap bit that software sets and clears over a small register bus. A copy of one non-volatile configuration bit, captured while reset is held. And the address of the access. Addresses above the window always go to the pass-through path, so they reach the targets the rest of the address map gives them.

The block also holds the non-volatile configuration bits. They are written one at a time through a set/clear port, and an erase input clears them all at once. The bits are not touched by reset. Two of them drive the brownout detector enable and the brownout reset enable, and these outputs follow the stored bits at once. The third bit picks Flash or ROM as the boot memory. Decoding uses only the copy of this bit that was sampled during the last reset.

Top module: `boot_remap_ctrl`

## Requirements
- R1: An access address at or below 0x0FFF_FFFF lies in the boot window. Any higher address asserts `sel_pass` and no other select, whatever the remap and configuration state.
- R2: When the remap bit is 1, an address in the boot window asserts `sel_sram`.
- R3: When the remap bit is 0 and the boot bit sampled at the last reset is 1, an address in the boot window asserts `sel_flash`.
- R4: When the remap bit is 0 and the sampled boot bit is 0, an address in the boot window asserts `sel_rom`.
- R5: The remap bit is 0 after reset. A bus write of the value 1 to word offset 0 sets it, and a bus write of the value 1 to offset 1 clears it. Any other data value or offset leaves it unchanged. `bus_rdata` shows the remap bit in bit 0, with all other bits zero. The change takes effect from the clock edge that takes the write.
- R6: `bod_en` equals configuration bit 1. A write through the set/clear port (`nvm_idx`=1, value `nvm_val`) shows on `bod_en` from the next clock edge.
- R7: `bor_en` equals configuration bit 2. A write with `nvm_idx`=2 updates it from the next clock edge.
- R8: While `erase` is high, configuration bits 1, 2 and 3 clear at the clock edge. This wins over a port write in the same cycle. After an erase, `bod_en` and `bor_en` are 0 and the next reset selects ROM.
- R9: Configuration bit 3 (`nvm_idx`=3) is captured as the boot bit on every clock edge while `rst` is high. Changing bit 3 while out of reset does not alter the decode until the next reset. The configuration bits keep their values through reset.
- R10: Exactly one of `sel_rom`, `sel_flash`, `sel_sram` and `sel_pass` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the boot bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word offset (0 set remap, 1 clear remap) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Remap bit in bit 0, other bits zero |
| nvm_wr | input | 1 | Configuration bit write strobe |
| nvm_idx | input | 2 | Index of the configuration bit to write (1..3) |
| nvm_val | input | 1 | New value for the indexed bit |
| erase | input | 1 | Clears configuration bits 1 to 3 |
| acc_addr | input | 32 | Address of the current access |
| sel_rom | output | 1 | ROM answers the access |
| sel_flash | output | 1 | Flash answers the access |
| sel_sram | output | 1 | First SRAM bank answers the access |
| sel_pass | output | 1 | Access goes to its normal target |
| bod_en | output | 1 | Brownout detector enable |
| bor_en | output | 1 | Brownout reset enable |

## Verification
The assertions assume that `rst` is high in the first clock cycle. They also assume that `erase` is held high during that reset, so the configuration bits, which have no reset, hold defined values before any check depends on them. They treat `acc_addr` as driven away from the clock edge, since the selects are combinational in it. The stimulus keeps to both assumptions. It opens with a reset that erases, and it changes every input only on the falling edge. Later resets and erases come at random, with accesses placed on both sides of the window boundary.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

    // Configuration bit positions; bit 0 is not governed by this block
    localparam int NVM_W    = 4;
    localparam int NVM_IW   = $clog2(NVM_W);
    localparam int BOD_BIT  = 1;
    localparam int BOR_BIT  = 2;
    localparam int BOOT_BIT = 3;

    typedef enum logic [1:0] {
        TGT_ROM   = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_SRAM  = 2'd2,
        TGT_PASS  = 2'd3
    } boot_tgt_e;

    typedef struct packed {
        logic rom;
        logic flash;
        logic sram;
        logic pass;
    } mem_sel_s;

    // Remap has priority over the sampled boot bit inside the window
    function automatic boot_tgt_e pick_target(input logic in_window,
                                              input logic remap,
                                              input logic boot_flash);
        boot_tgt_e t;
        if (!in_window)      t = TGT_PASS;
        else if (remap)      t = TGT_SRAM;
        else if (boot_flash) t = TGT_FLASH;
        else                 t = TGT_ROM;
        return t;
    endfunction

    function automatic mem_sel_s tgt_to_sel(input boot_tgt_e t);
        mem_sel_s s;
        s       = '0;
        s.rom   = (t == TGT_ROM);
        s.flash = (t == TGT_FLASH);
        s.sram  = (t == TGT_SRAM);
        s.pass  = (t == TGT_PASS);
        return s;
    endfunction

endpackage

// File: rtl/remap_reg.sv
module remap_reg #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              remap,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [REG_AW-1:0] OFS_SET = REG_AW'(0);
    localparam logic [REG_AW-1:0] OFS_CLR = REG_AW'(1);
    localparam logic [DATA_W-1:0] CMD_GO  = DATA_W'(1);

    logic cmd_hit;
    logic remap_q;

    assign cmd_hit = wr && (wdata == CMD_GO);

    always_ff @(posedge clk) begin
        if (rst)                              remap_q <= 1'b0;
        else if (cmd_hit && addr == OFS_SET)  remap_q <= 1'b1;
        else if (cmd_hit && addr == OFS_CLR)  remap_q <= 1'b0;
    end

    assign remap = remap_q;
    assign rdata = {{(DATA_W-1){1'b0}}, remap_q};
endmodule

// File: rtl/nvm_store.sv
module nvm_store
    import boot_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              erase,
    input  logic              wr,
    input  logic [NVM_IW-1:0] idx,
    input  logic              val,
    output logic [NVM_W-1:1]  bits,
    output logic              boot_flash
);
    logic [NVM_W-1:1] bits_q;
    logic [NVM_W-1:1] bits_d;
    logic             boot_q;

    // One next-state term per stored bit; erase clears every stored bit
    for (genvar b = 1; b < NVM_W; b++) begin : g_bit
        assign bits_d[b] = erase                           ? 1'b0 :
                           (wr && idx == NVM_IW'(b))       ? val  :
                                                             bits_q[b];
    end

    // No reset: the bits model non-volatile storage
    always_ff @(posedge clk) begin
        bits_q <= bits_d;
    end

    // Boot choice is captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) boot_q <= bits_q[BOOT_BIT];
    end

    assign bits       = bits_q;
    assign boot_flash = boot_q;
endmodule

// File: rtl/boot_decoder.sv
module boot_decoder
    import boot_remap_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BOOT_LAST = ADDR_W'(32'h0FFF_FFFF)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              remap,
    input  logic              boot_flash,
    output mem_sel_s          sel
);
    logic      in_window;
    boot_tgt_e tgt;

    assign in_window = (addr <= BOOT_LAST);
    assign tgt       = pick_target(in_window, remap, boot_flash);
    assign sel       = tgt_to_sel(tgt);
endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
    import boot_remap_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                REG_AW    = 2,
    parameter logic [ADDR_W-1:0] BOOT_LAST = ADDR_W'(32'h0FFF_FFFF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              nvm_wr,
    input  logic [NVM_IW-1:0] nvm_idx,
    input  logic              nvm_val,
    input  logic              erase,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              sel_rom,
    output logic              sel_flash,
    output logic              sel_sram,
    output logic              sel_pass,
    output logic              bod_en,
    output logic              bor_en
);
    logic             remap;
    logic             boot_flash;
    logic [NVM_W-1:1] nvm_bits;
    mem_sel_s         sel;

    remap_reg #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_remap (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .remap (remap),
        .rdata (bus_rdata)
    );

    nvm_store u_nvm (
        .clk        (clk),
        .rst        (rst),
        .erase      (erase),
        .wr         (nvm_wr),
        .idx        (nvm_idx),
        .val        (nvm_val),
        .bits       (nvm_bits),
        .boot_flash (boot_flash)
    );

    boot_decoder #(.ADDR_W(ADDR_W), .BOOT_LAST(BOOT_LAST)) u_dec (
        .addr       (acc_addr),
        .remap      (remap),
        .boot_flash (boot_flash),
        .sel        (sel)
    );

    assign sel_rom   = sel.rom;
    assign sel_flash = sel.flash;
    assign sel_sram  = sel.sram;
    assign sel_pass  = sel.pass;
    assign bod_en    = nvm_bits[BOD_BIT];
    assign bor_en    = nvm_bits[BOR_BIT];
endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk
    import boot_remap_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                REG_AW    = 2,
    parameter logic [ADDR_W-1:0] BOOT_LAST = ADDR_W'(32'h0FFF_FFFF)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              nvm_wr,
    input logic [NVM_IW-1:0] nvm_idx,
    input logic              nvm_val,
    input logic              erase,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              sel_rom,
    input logic              sel_flash,
    input logic              sel_sram,
    input logic              sel_pass,
    input logic              bod_en,
    input logic              bor_en
);
    logic win;
    assign win = (acc_addr <= BOOT_LAST);

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $countones({sel_rom, sel_flash, sel_sram, sel_pass}) == 1);  // R10

    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (rst)
        !win |-> sel_pass);  // R1

    AST_REMAP_SRAM: assert property (@(posedge clk) disable iff (rst)
        (win && bus_rdata[0]) |-> sel_sram);  // R2

    AST_REMAP_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_AW'(0) && bus_wdata == DATA_W'(1)) |=> bus_rdata[0]);  // R5

    AST_REMAP_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_AW'(1) && bus_wdata == DATA_W'(1)) |=> !bus_rdata[0]);  // R5

    AST_BOD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (nvm_wr && !erase && nvm_idx == NVM_IW'(BOD_BIT)) |=> (bod_en == $past(nvm_val)));  // R6

    AST_BOR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (nvm_wr && !erase && nvm_idx == NVM_IW'(BOR_BIT)) |=> (bor_en == $past(nvm_val)));  // R7

    AST_ERASE_OFF: assert property (@(posedge clk) disable iff (rst)
        erase |=> (!bod_en && !bor_en));  // R8

    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && win && !bus_rdata[0] && $past(win && !bus_rdata[0]))
        |-> $stable(sel_flash));  // R9
endmodule

bind boot_remap_ctrl boot_remap_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .BOOT_LAST(BOOT_LAST)
) u_chk (.*);

// File: tb/boot_remap_ctrl_test.sv
module boot_remap_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nvm_wr = 1'b0;
    logic [1:0]  nvm_idx = '0;
    logic        nvm_val = 1'b0;
    logic        erase = 1'b1;
    logic [31:0] acc_addr = '0;
    logic        sel_rom, sel_flash, sel_sram, sel_pass, bod_en, bor_en;

    boot_remap_ctrl uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nvm_wr(nvm_wr),
        .nvm_idx(nvm_idx), .nvm_val(nvm_val), .erase(erase),
        .acc_addr(acc_addr), .sel_rom(sel_rom), .sel_flash(sel_flash),
        .sel_sram(sel_sram), .sel_pass(sel_pass), .bod_en(bod_en), .bor_en(bor_en)
    );

    always #4 clk = ~clk;  // 125 MHz

    int errors = 0;
    int checks = 0;
    bit armed  = 1'b0;

    // Behavioural reference state
    bit       m_remap = 1'b0;
    bit       m_boot  = 1'b0;
    bit [3:0] m_nvm   = '0;
    bit       m_prev_erase = 1'b0;

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Drive one cycle of inputs, compare outputs, then advance the model
    task automatic cyc(input bit r, input bit w, input bit [1:0] a, input bit [31:0] d,
                       input bit nw, input bit [1:0] ni, input bit nv, input bit er,
                       input bit [31:0] ad);
        bit        inwin;
        bit [3:0]  exp_sel;
        string     tg;
        @(negedge clk);
        rst = r; bus_wr = w; bus_addr = a; bus_wdata = d;
        nvm_wr = nw; nvm_idx = ni; nvm_val = nv; erase = er; acc_addr = ad;
        #1;
        if (armed) begin
            inwin = (ad <= 32'h0FFF_FFFF);
            if (!inwin)      begin exp_sel = 4'b0001; tg = "R1"; end
            else if (m_remap) begin exp_sel = 4'b0010; tg = "R2"; end
            else if (m_boot)  begin exp_sel = 4'b0100; tg = "R3"; end
            else              begin exp_sel = 4'b1000; tg = "R4"; end
            if (inwin && !m_remap && (m_boot != m_nvm[3])) tg = "R9";
            check(tg, "select {rom,flash,sram,pass}",
                  {sel_rom, sel_flash, sel_sram, sel_pass}, exp_sel);
            check("R10", "active select count",
                  $countones({sel_rom, sel_flash, sel_sram, sel_pass}), 1);
            check("R5", "bus_rdata", bus_rdata, {31'b0, m_remap});
            check(m_prev_erase ? "R8" : "R6", "bod_en", bod_en, m_nvm[1]);
            check(m_prev_erase ? "R8" : "R7", "bor_en", bor_en, m_nvm[2]);
        end
        @(posedge clk);
        if (r) m_boot = m_nvm[3];
        if (r) m_remap = 1'b0;
        else if (w && d == 32'd1 && a == 2'd0) m_remap = 1'b1;
        else if (w && d == 32'd1 && a == 2'd1) m_remap = 1'b0;
        if (er) m_nvm[3:1] = '0;
        else if (nw && ni != 2'd0) m_nvm[ni] = nv;
        m_prev_erase = er;
    endtask

    task automatic idle(input bit [31:0] ad);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, ad);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        // Power-up: reset with erase so the non-volatile bits are defined
        cyc(1, 0, 0, 0, 0, 0, 0, 1, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 1, 0);
        armed = 1'b1;
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        // Reset state: ROM at 0, brownout off, remap 0 (R4, R5, R8)
        idle(32'h0000_0000);
        idle(32'h0FFF_FFFF);
        idle(32'h1000_0000);                          // R1 boundary
        idle(32'hFFFF_FFFF);
        // Set boot bit without reset: decode stays ROM (R9)
        cyc(0, 0, 0, 0, 1, 3, 1, 0, 32'h0000_0100);
        idle(32'h0000_0100);
        // Reset samples it: Flash (R3)
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        idle(32'h0000_0040);
        // Remap set, ignored writes, remap clear (R2, R5)
        cyc(0, 1, 0, 32'd1, 0, 0, 0, 0, 32'h0000_0000);
        idle(32'h0ABC_0000);
        cyc(0, 1, 1, 32'd3, 0, 0, 0, 0, 32'h0000_0010);
        cyc(0, 1, 2, 32'd1, 0, 0, 0, 0, 32'h0000_0010);
        idle(32'h2000_0000);
        cyc(0, 1, 1, 32'd1, 0, 0, 0, 0, 32'h0000_0010);
        idle(32'h0000_0010);
        // Brownout controls (R6, R7)
        cyc(0, 0, 0, 0, 1, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 2, 1, 0, 0);
        idle(0);
        cyc(0, 0, 0, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 1, 1, 0, 0);
        // Erase beats a same-cycle write; next reset boots ROM (R8)
        cyc(0, 0, 0, 0, 1, 2, 1, 1, 0);
        idle(0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        idle(0);
        // Random traffic around the window edge
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] ad;
            bit [31:0] d;
            case ($urandom_range(0, 4))
                0: ad = 32'h0FFF_FFFF;
                1: ad = 32'h1000_0000;
                2: ad = $urandom_range(0, 32'h0FFF_FFFF);
                default: ad = $urandom;
            endcase
            d = ($urandom_range(0, 3) != 0) ? 32'd1 : $urandom_range(0, 7);
            cyc($urandom_range(0, 49) == 0,
                $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)), d,
                $urandom_range(0, 5) == 0, 2'($urandom_range(0, 3)),
                1'($urandom_range(0, 1)), $urandom_range(0, 39) == 0, ad);
        end
        report();
        $finish;
    end
endmodule